// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned operands and a carry-in with no clock. Its result is the sum and a carry-out. The operand bits are split into fixed four-bit groups.

Each bit position forms two terms. The carry-make term is the AND of its two operand bits. The carry-pass term is the XOR of the two bits, which is the same XOR the sum path needs. Inside a group, a lookahead unit computes every internal carry as a flat sum of products of these terms and the group carry-in. No carry waits on the carry logic of a lower bit.

Each group also reports a group-make and a group-pass signal. A second lookahead unit, with the same structure, turns these into the carry into every group and into the final carry-out. The top-level make and pass signals are brought out as ports, so a wider adder can stack another lookahead level on top of this one.

Top module: `lookahead_adder`

## Requirements
- R1: For every `opa_i`, `opb_i` and `cin_i`, the 17-bit value {`cout_o`, `sum_o`} equals `opa_i + opb_i + cin_i` in unsigned arithmetic.
- R2: `prop_o` is 1 exactly when every bit of `opa_i` differs from the bit at the same position of `opb_i`, that is when `opa_i ^ opb_i` is all ones.
- R3: `gen_o` is 1 exactly when `opa_i + opb_i`, with no carry-in, overflows 16 bits. `gen_o` and `prop_o` are never 1 together.
- R4: `cout_o` equals `gen_o OR (prop_o AND cin_i)`.
- R5: When every bit pair differs and `cin_i` is 1, `sum_o` is all zeros and `cout_o` is 1.
- R6: A carry that enters or leaves a four-bit group (bits 3:0, 7:4, 11:8, 15:12) reaches the correct sum bits. The lookahead carry out of each group equals the carry out of its most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| gen_o | output | 1 | Whole-adder carry-make signal |
| prop_o | output | 1 | Whole-adder carry-pass signal |

## Verification
The block holds no state. A wrong carry term therefore shows at the ports at once, as a flipped sum bit, a wrong carry-out or a wrong make/pass flag, for the same input vector.

A fault in a group's carry-make or carry-pass term shows only for operand patterns that send a carry across that group. For this reason the directed vectors force carries into and out of each group boundary, and include the case where every bit passes the carry.

The lookahead carries are also compared, inside the design, against the simple one-bit carry recurrence. A flattened term that drops a product fails there on the first vector that needs that product.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;
  localparam int unsigned GRP_W = 4;

  // reference sum of a group, used by cross-checks
  function automatic logic [GRP_W:0] grp_ref_sum(
    input logic [GRP_W-1:0] x,
    input logic [GRP_W-1:0] y,
    input logic             ci
  );
    return {1'b0, x} + {1'b0, y} + {{GRP_W{1'b0}}, ci};
  endfunction
endpackage

// File: rtl/la_carry_unit.sv
module la_carry_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] mk_i,
  input  logic [N-1:0] ps_i,
  input  logic         cin_i,
  output logic [N-1:0] cin_vec_o,
  output logic         grp_mk_o,
  output logic         grp_ps_o,
  output logic         cout_o
);
  // flat sum of products: carry into position idx
  function automatic logic flat_carry(
    input logic [N-1:0] g,
    input logic [N-1:0] p,
    input logic         ci,
    input int unsigned  idx
  );
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int unsigned j = 0; j < N; j++) begin
      if (j < idx) begin
        prod = g[j];
        for (int unsigned k = 0; k < N; k++)
          if (k > j && k < idx) prod = prod & p[k];
        acc = acc | prod;
      end
    end
    prod = ci;
    for (int unsigned k = 0; k < N; k++)
      if (k < idx) prod = prod & p[k];
    return acc | prod;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_carry
      assign cin_vec_o[gi] = flat_carry(mk_i, ps_i, cin_i, gi);
    end
  endgenerate

  assign grp_mk_o = flat_carry(mk_i, ps_i, 1'b0, N);
  assign grp_ps_o = &ps_i;
  assign cout_o   = grp_mk_o | (grp_ps_o & cin_i);

  always_comb begin
    // R6
    carry_chain_chk: assert (cin_vec_o[0] == cin_i);
    for (int unsigned i = 1; i < N; i++) begin
      // R6
      carry_step_chk: assert (cin_vec_o[i] ==
        (mk_i[i-1] | (ps_i[i-1] & cin_vec_o[i-1])));
    end
    // R6
    grp_cout_chk: assert (cout_o == (mk_i[N-1] | (ps_i[N-1] & cin_vec_o[N-1])));
  end
endmodule

// File: rtl/la_group.sv
module la_group
  import lookahead_pkg::*;
(
  input  logic [GRP_W-1:0] opa_i,
  input  logic [GRP_W-1:0] opb_i,
  input  logic             cin_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             grp_mk_o,
  output logic             grp_ps_o
);
  logic [GRP_W-1:0] mk;
  logic [GRP_W-1:0] ps;
  logic [GRP_W-1:0] cvec;
  logic             grp_cout;

  genvar bi;
  generate
    for (bi = 0; bi < GRP_W; bi++) begin : g_slice
      assign mk[bi]    = opa_i[bi] & opb_i[bi];
      assign ps[bi]    = opa_i[bi] ^ opb_i[bi];
      assign sum_o[bi] = ps[bi] ^ cvec[bi];
    end
  endgenerate

  la_carry_unit #(.N(GRP_W)) u_lcu (
    .mk_i      (mk),
    .ps_i      (ps),
    .cin_i     (cin_i),
    .cin_vec_o (cvec),
    .grp_mk_o  (grp_mk_o),
    .grp_ps_o  (grp_ps_o),
    .cout_o    (grp_cout)
  );

  always_comb begin
    // R1
    grp_sum_chk: assert ({grp_cout, sum_o} == grp_ref_sum(opa_i, opb_i, cin_i));
  end
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import lookahead_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             gen_o,
  output logic             prop_o
);
  localparam int unsigned NGRP = WIDTH / GRP_W;

  logic [NGRP-1:0] grp_mk;
  logic [NGRP-1:0] grp_ps;
  logic [NGRP-1:0] grp_cin;

  genvar gi;
  generate
    for (gi = 0; gi < NGRP; gi++) begin : g_grp
      la_group u_grp (
        .opa_i    (opa_i[gi*GRP_W +: GRP_W]),
        .opb_i    (opb_i[gi*GRP_W +: GRP_W]),
        .cin_i    (grp_cin[gi]),
        .sum_o    (sum_o[gi*GRP_W +: GRP_W]),
        .grp_mk_o (grp_mk[gi]),
        .grp_ps_o (grp_ps[gi])
      );
    end
  endgenerate

  la_carry_unit #(.N(NGRP)) u_top_lcu (
    .mk_i      (grp_mk),
    .ps_i      (grp_ps),
    .cin_i     (cin_i),
    .cin_vec_o (grp_cin),
    .grp_mk_o  (gen_o),
    .grp_ps_o  (prop_o),
    .cout_o    (cout_o)
  );

  always_comb begin
    // R4
    top_cout_chk: assert (cout_o == (gen_o | (prop_o & cin_i)));
    // R3
    mk_ps_excl_chk: assert (!(gen_o && prop_o));
    // R5
    all_pass_chk: assert (!(prop_o && cin_i) || (cout_o && sum_o == '0));
    // R2
    pass_match_chk: assert (prop_o == (&(opa_i ^ opb_i)));
  end
endmodule

// File: tb/lookahead_adder_bench.sv
`timescale 1ns/1ps
module lookahead_adder_bench;
  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        ci;
  logic [15:0] s;
  logic        co, gn, pr;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  lookahead_adder u_lookahead_adder (
    .opa_i(a), .opb_i(b), .cin_i(ci),
    .sum_o(s), .cout_o(co), .gen_o(gn), .prop_o(pr)
  );

  function automatic logic [16:0] ref_total(logic [15:0] x, logic [15:0] y, logic c);
    int unsigned t;
    t = int'(x) + int'(y) + int'(c);
    return t[16:0];
  endfunction

  function automatic logic ref_pass(logic [15:0] x, logic [15:0] y);
    for (int i = 0; i < 16; i++) if (x[i] == y[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h", req, a, b, ci, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] x, logic [15:0] y, logic c);
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
    chk("R1", {co, s}, ref_total(x, y, c));
    chk("R2", {16'd0, pr}, {16'd0, ref_pass(x, y)});
    chk("R3", {16'd0, gn}, {16'd0, ref_total(x, y, 1'b0) > 17'hFFFF});
    chk("R4", {16'd0, co}, {16'd0, ref_total(x, y, 1'b0) > 17'hFFFF ||
                                   (ref_pass(x, y) && c)});
  endtask

  initial begin
    int unsigned seed;
    a = '0; b = '0; ci = 1'b0;
    @(negedge clk);
    // quiet state with zero inputs (R1)
    chk("R1", {co, s, gn, pr}[18:2], 17'd0);
    // R5 all bit pairs pass the carry
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R5", {co, s}, 17'h10000);
    apply(16'hAAAA, 16'h5555, 1'b1);
    chk("R5", {co, s}, 17'h10000);
    apply(16'hAAAA, 16'h5555, 1'b0);
    // R6 carries across each group boundary
    apply(16'h000F, 16'h0001, 1'b0);
    chk("R6", {1'b0, s}, 17'h00010);
    apply(16'h00FF, 16'h0000, 1'b1);
    chk("R6", {1'b0, s}, 17'h00100);
    apply(16'h0FFF, 16'h0001, 1'b0);
    chk("R6", {1'b0, s}, 17'h01000);
    apply(16'h0F0F, 16'h0101, 1'b0);
    chk("R6", {1'b0, s}, 17'h01010);
    // R3 make signals
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h7FFF, 16'h8000, 1'b0);
    seed = 32'h1D2C;
    void'($urandom(seed));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = 16'($urandom);
      if (i % 4 == 0) y = ~x ^ (16'h1 << (i % 16));
      if (i % 8 == 1) y = ~x;
      apply(x, y, 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule